// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer

This block sequences a successive-approximation converter through a contiguous run of analog inputs in one pass and then stops. Software programs a control word holding a run bit, a group bit, a two-bit channel count, a mode bit, an interrupt enable and a completion flag. Setting the run bit, by a register write or by a pulse on an external trigger pin, launches the pass. The sequencer hands the converter a one-cycle start pulse with a channel number and waits for a done strobe that carries the result word.

Eight inputs form two groups of four. Each finished conversion is stored in a per-channel result register, and the next channel is launched in the following cycle. After the last selected channel, hardware drops the run bit, raises the completion flag and, if enabled, the interrupt line. Clearing the run bit mid-pass aborts the pass and discards the result still in flight. The next start always begins again at the group's first channel.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word at address 0 reads as zero, `irq` is low and `conv_start` is low.
- R2: A write to address 0 with the run bit (bit 0) set, or a one-cycle high level on `ext_trig`, sets the run bit. The first `conv_start` pulse then appears in the second cycle after the cycle in which the write or trigger was presented.
- R3: The group bit (bit 1) picks the first channel: 0 selects channel 0 and 1 selects channel 4. `conv_chan` carries the channel number in binary.
- R4: In multi mode (bit 4 = 1) the count field (bits 3:2) values 0, 1, 2 and 3 convert 1, 2, 3 and 4 channels, in ascending order from the group's first channel.
- R5: In single mode (bit 4 = 0) exactly one conversion is made, on the channel equal to the group's first channel plus the count field.
- R6: When another channel remains, its `conv_start` is asserted in the cycle right after the cycle holding the `conv_done` strobe.
- R7: The `conv_result` value presented with `conv_done` is stored in the result register of the channel being converted. Channel n's register reads at address 8+n, zero-extended. Reads return data one cycle after the address is presented.
- R8: When the last selected channel completes, the run bit is cleared and the completion flag (bit 6) is set.
- R9: `irq` equals the completion flag AND the interrupt enable (bit 5). The flag stays set until a write to address 0 carries bit 6 = 0. A write with bit 6 = 1 leaves the flag unchanged and never sets it.
- R10: Clearing the run bit while a conversion is in flight stops the pass: no further `conv_start` is issued, the in-flight result is not stored, and the completion flag is not set.
- R11: A start after an abort begins at the group's first channel. If the aborted conversion is still outstanding, the new `conv_start` is issued in the cycle after that conversion's `conv_done` strobe.
- R12: A single write that changes group, count or mode and sets the run bit makes the pass it starts use the new settings.
- R13: `conv_start` is a one-cycle pulse, and no new pulse is issued while a conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write address (0 = control word) |
| reg_wr_data | input | 7 | Control word write data |
| reg_rd_addr | input | 4 | Register read address (0 = control, 8..15 = results) |
| reg_rd_data | output | 16 | Registered read data |
| ext_trig | input | 1 | External start trigger |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | Conversion finished strobe |
| conv_result | input | 10 | Conversion result, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs passes over both groups with every count value in multi mode, so that the starting channel, the pass length and the ascending order are each shown to be separate effects. A single-mode pass shows that the count field then selects a channel offset rather than a length. A trigger-pin start is compared with a register start to confirm both give the same launch latency. Two abort patterns follow: a plain abort shows that the in-flight result is dropped and the completion flag is not set, and an abort followed at once by a restart in a new group shows that the restart waits for the stale strobe and begins at the new group's first channel.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Channel organisation
  localparam int CH_PER_GRP = 4;
  localparam int NUM_GRP    = 2;
  localparam int NUM_CH     = CH_PER_GRP * NUM_GRP;
  localparam int OFF_W      = $clog2(CH_PER_GRP);
  localparam int GRP_W      = $clog2(NUM_GRP);
  localparam int CH_W       = $clog2(NUM_CH);

  // Control word layout, LSB first: run, group, count, multi, irq_en, done
  localparam int BIT_RUN  = 0;
  localparam int BIT_GRP  = BIT_RUN + 1;
  localparam int BIT_CNT  = BIT_GRP + GRP_W;
  localparam int BIT_MODE = BIT_CNT + OFF_W;
  localparam int BIT_IE   = BIT_MODE + 1;
  localparam int BIT_DONE = BIT_IE + 1;
  localparam int CTRL_W   = BIT_DONE + 1;

  typedef struct packed {
    logic             done;
    logic             irq_en;
    logic             multi;
    logic [OFF_W-1:0] count;
    logic [GRP_W-1:0] group;
    logic             run;
  } ctrl_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CONV  = 2'd1,
    SQ_DRAIN = 2'd2
  } sq_state_e;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int              AW        = 4,
  parameter logic [AW-1:0]   CTRL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              ext_trig,
  input  logic              pass_done,
  output ctrl_t             ctrl_o,
  output logic              irq_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  ctrl_t wr_word;
  logic  hit;

  assign hit     = wr_en && (wr_addr == CTRL_ADDR);
  assign wr_word = ctrl_t'(wr_data);

  always_comb begin
    ctrl_d = ctrl_q;
    if (pass_done) begin
      ctrl_d.run = 1'b0;
    end
    if (ext_trig) begin
      ctrl_d.run = 1'b1;
    end
    if (hit) begin
      ctrl_d.run    = wr_word.run;
      ctrl_d.group  = wr_word.group;
      ctrl_d.count  = wr_word.count;
      ctrl_d.multi  = wr_word.multi;
      ctrl_d.irq_en = wr_word.irq_en;
      if (!wr_word.done) begin
        ctrl_d.done = 1'b0;
      end
    end
    // completion wins over a clearing write in the same cycle
    if (pass_done) begin
      ctrl_d.done = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_o  <= ctrl_d.done && ctrl_d.irq_en;
    end
  end

  assign ctrl_o = ctrl_q;

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> ctrl_q.done); // R8
  AST_RUN_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (pass_done && !hit && !ext_trig) |=> !ctrl_q.run); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.done && !(hit && !wr_word.done)) |=> ctrl_q.done); // R9
  AST_DONE_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.done && !pass_done) |=> !ctrl_q.done); // R9
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq_o == (ctrl_q.done && ctrl_q.irq_en)); // R9

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [GRP_W-1:0] group,
  input  logic [OFF_W-1:0] count,
  input  logic             multi,
  input  logic             conv_done,
  output logic             conv_start_o,
  output logic [CH_W-1:0]  conv_chan_o,
  output logic             res_we_o,
  output logic             pass_done_o
);

  sq_state_e        st_q;
  logic [GRP_W-1:0] grp_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] last_q;
  logic             launch;
  logic             at_last;

  // A new pass may begin from idle, or from draining once the stale strobe lands
  assign launch   = run && ((st_q == SQ_IDLE) || ((st_q == SQ_DRAIN) && conv_done));
  assign at_last  = (off_q == last_q);
  assign res_we_o    = (st_q == SQ_CONV) && conv_done && run;
  assign pass_done_o = res_we_o && at_last;
  assign conv_chan_o = {grp_q, off_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= SQ_IDLE;
      grp_q        <= '0;
      off_q        <= '0;
      last_q       <= '0;
      conv_start_o <= 1'b0;
    end else begin
      conv_start_o <= 1'b0;
      if (launch) begin
        st_q         <= SQ_CONV;
        grp_q        <= group;
        off_q        <= multi ? '0 : count;
        last_q       <= count;
        conv_start_o <= 1'b1;
      end else begin
        case (st_q)
          SQ_CONV: begin
            if (!run) begin
              st_q <= conv_done ? SQ_IDLE : SQ_DRAIN;
            end else if (conv_done) begin
              if (at_last) begin
                st_q <= SQ_IDLE;
              end else begin
                off_q        <= off_q + 1'b1;
                conv_start_o <= 1'b1;
              end
            end
          end
          SQ_DRAIN: begin
            if (conv_done) begin
              st_q <= SQ_IDLE;
            end
          end
          default: st_q <= SQ_IDLE;
        endcase
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o); // R13
  AST_NEXT_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (res_we_o && !pass_done_o) |=> (conv_start_o && $stable(grp_q))); // R6
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_CONV && !run && !conv_done) |=> (!conv_start_o && st_q == SQ_DRAIN)); // R10
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_DRAIN && !conv_done) |=> !conv_start_o); // R11

endmodule

// File: rtl/adc_seq_rbank.sv
module adc_seq_rbank #(
  parameter int RES_W   = 10,
  parameter int DEPTH   = 8,
  parameter bit USE_RAM = 1'b1,
  localparam int A_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [A_W-1:0]   waddr,
  input  logic [RES_W-1:0] wdata,
  input  logic [A_W-1:0]   raddr,
  output logic [RES_W-1:0] rdata
);

  generate
    if (USE_RAM) begin : g_ram
      logic [RES_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (we) begin
          mem[waddr] <= wdata;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          rdata <= '0;
        end else begin
          rdata <= mem[raddr];
        end
      end
    end else begin : g_flop
      logic [DEPTH-1:0][RES_W-1:0] slot;

      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
          if (rst) begin
            slot[i] <= '0;
          end else if (we && (waddr == A_W'(i))) begin
            slot[i] <= wdata;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          rdata <= '0;
        end else begin
          rdata <= slot[raddr];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int DW      = 16,
  parameter int AW      = 4,
  parameter bit USE_RAM = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [AW-1:0]     reg_wr_addr,
  input  logic [CTRL_W-1:0] reg_wr_data,
  input  logic [AW-1:0]     reg_rd_addr,
  output logic [DW-1:0]     reg_rd_data,
  input  logic              ext_trig,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              irq
);

  localparam logic [AW-1:0] CTRL_ADDR = '0;

  ctrl_t             ctrl;
  logic              res_we;
  logic              pass_done;
  logic [RES_W-1:0]  bank_q;
  logic              sel_bank_q;
  logic [CTRL_W-1:0] ctrl_rd_q;

  adc_seq_regs #(
    .AW       (AW),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_wr_addr),
    .wr_data  (reg_wr_data),
    .ext_trig (ext_trig),
    .pass_done(pass_done),
    .ctrl_o   (ctrl),
    .irq_o    (irq)
  );

  adc_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .run         (ctrl.run),
    .group       (ctrl.group),
    .count       (ctrl.count),
    .multi       (ctrl.multi),
    .conv_done   (conv_done),
    .conv_start_o(conv_start),
    .conv_chan_o (conv_chan),
    .res_we_o    (res_we),
    .pass_done_o (pass_done)
  );

  adc_seq_rbank #(
    .RES_W  (RES_W),
    .DEPTH  (NUM_CH),
    .USE_RAM(USE_RAM)
  ) u_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (res_we),
    .waddr(conv_chan),
    .wdata(conv_result),
    .raddr(reg_rd_addr[CH_W-1:0]),
    .rdata(bank_q)
  );

  // Read path: control snapshot registered alongside the bank read
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_bank_q <= 1'b0;
      ctrl_rd_q  <= '0;
    end else begin
      sel_bank_q <= reg_rd_addr[AW-1];
      ctrl_rd_q  <= (reg_rd_addr == CTRL_ADDR) ? ctrl : '0;
    end
  end

  always_comb begin
    reg_rd_data = '0;
    if (sel_bank_q) begin
      reg_rd_data[RES_W-1:0] = bank_q;
    end else begin
      reg_rd_data[CTRL_W-1:0] = ctrl_rd_q;
    end
  end

  AST_STORE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (ctrl.run && conv_done)); // R10
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl.irq_en); // R9

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

  localparam int LAT = 3;

  typedef struct packed {
    logic [2:0] ch;
    logic       b2b;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [6:0]  reg_wr_data = '0;
  logic [3:0]  reg_rd_addr = '0;
  logic [15:0] reg_rd_data;
  logic        ext_trig = 1'b0;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_result = '0;
  logic        irq;

  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic [6:0]  seed = '0;
  exp_t        sb_q[$];
  logic [9:0]  exp_mem [8];
  logic [7:0]  exp_ok = '0;

  // converter model state
  logic        m_busy = 1'b0;
  int          m_cnt = 0;
  logic [2:0]  m_ch = '0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data),
    .ext_trig   (ext_trig),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .conv_result(conv_result),
    .irq        (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Fixed-latency converter model
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (m_busy) begin
      if (m_cnt == 1) begin
        conv_done   <= 1'b1;
        conv_result <= {seed, m_ch};
        m_busy = 1'b0;
      end else begin
        m_cnt--;
      end
    end
    if (!rst && conv_start) begin
      if (m_busy) begin
        n_chk++;
        n_bad++;
        $display("FAIL R13/R11: actual start while busy expected idle converter");
      end
      m_busy = 1'b1;
      m_cnt  = LAT;
      m_ch   = conv_chan;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && conv_start) begin
      if (sb_q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R10/R4: actual unexpected start on ch %0d expected none", conv_chan);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        chk("R3/R4/R5 channel order", 32'(conv_chan), 32'(it.ch));
        if (it.b2b) begin
          chk("R6 start follows strobe", 32'(conv_done), 32'd1);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  task automatic wr_ctrl(input logic run, input logic grp, input logic [1:0] cnt,
                         input logic multi, input logic ie, input logic keep_done);
    reg_wr_en   = 1'b1;
    reg_wr_addr = 4'd0;
    reg_wr_data = {keep_done, ie, multi, cnt, grp, run};
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_rd_addr = a;
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic expect_pass(input logic grp, input logic [1:0] cnt, input logic multi);
    seed = seed + 7'd1;
    if (multi) begin
      for (int o = 0; o <= int'(cnt); o++) begin
        sb_q.push_back('{ch: 3'({grp, 2'(o)}), b2b: (o != 0)});
      end
    end else begin
      sb_q.push_back('{ch: {grp, cnt}, b2b: 1'b0});
    end
  endtask

  task automatic commit(input logic grp, input logic [1:0] cnt, input logic multi);
    if (multi) begin
      for (int o = 0; o <= int'(cnt); o++) begin
        exp_mem[{grp, 2'(o)}] = {seed, grp, 2'(o)};
        exp_ok[{grp, 2'(o)}]  = 1'b1;
      end
    end else begin
      exp_mem[{grp, cnt}] = {seed, grp, cnt};
      exp_ok[{grp, cnt}]  = 1'b1;
    end
  endtask

  task automatic wait_idle();
    logic [15:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(4'd0, d);
      if (!d[0]) break;
    end
  endtask

  task automatic run_pass(input logic grp, input logic [1:0] cnt, input logic multi, input logic ie);
    expect_pass(grp, cnt, multi);
    wr_ctrl(1'b1, grp, cnt, multi, ie, 1'b1);
    wait_idle();
    commit(grp, cnt, multi);
  endtask

  task automatic check_results(input string req);
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      if (exp_ok[i]) begin
        rd(4'(8 + i), d);
        chk(req, 32'(d), 32'(exp_mem[i]));
      end
    end
  endtask

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, d);
    chk("R1 ctrl after reset", 32'(d), 32'd0);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R1 conv_start after reset", 32'(conv_start), 32'd0);

    // R2 launch latency, R3/R4 group 0 three channels, R12 write with settings
    expect_pass(1'b0, 2'd2, 1'b1);
    wr_ctrl(1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1);
    chk("R2 no start yet", 32'(conv_start), 32'd0);
    @(negedge clk);
    chk("R2 start two cycles after write", 32'(conv_start), 32'd1);
    wait_idle();
    commit(1'b0, 2'd2, 1'b1);
    rd(4'd0, d);
    chk("R8 run cleared", 32'(d[0]), 32'd0);
    chk("R8 done set", 32'(d[6]), 32'd1);
    chk("R9 irq with enable", 32'(irq), 32'd1);
    check_results("R7 group 0 results");

    // R9 done clear and no software set
    wr_ctrl(1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    rd(4'd0, d);
    chk("R9 done cleared", 32'(d[6]), 32'd0);
    chk("R9 irq dropped", 32'(irq), 32'd0);
    wr_ctrl(1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rd(4'd0, d);
    chk("R9 write of 1 does not set done", 32'(d[6]), 32'd0);
    chk("R9 irq stays low", 32'(irq), 32'd0);

    // R3 group 1, four channels, interrupt disabled
    run_pass(1'b1, 2'd3, 1'b1, 1'b0);
    rd(4'd0, d);
    chk("R8 done after group 1", 32'(d[6]), 32'd1);
    chk("R9 irq masked", 32'(irq), 32'd0);
    check_results("R7 group 1 results");

    // R4 remaining counts
    run_pass(1'b1, 2'd0, 1'b1, 1'b0);
    run_pass(1'b0, 2'd1, 1'b1, 1'b0);
    check_results("R4 count 0 and 1 results");

    // R5 single mode: channel 6 only
    run_pass(1'b1, 2'd2, 1'b0, 1'b0);
    check_results("R5 single mode results");

    // R2 external trigger start
    wr_ctrl(1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0);
    expect_pass(1'b0, 2'd1, 1'b1);
    ext_trig = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0;
    chk("R2 trigger no start yet", 32'(conv_start), 32'd0);
    @(negedge clk);
    chk("R2 trigger start latency", 32'(conv_start), 32'd1);
    wait_idle();
    commit(1'b0, 2'd1, 1'b1);
    check_results("R2 trigger pass results");

    // R10 abort during second channel
    wr_ctrl(1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0);
    expect_pass(1'b0, 2'd3, 1'b1);
    wr_ctrl(1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1);
    do @(negedge clk); while (!(conv_start && conv_chan == 3'd1));
    wr_ctrl(1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1);
    sb_q.delete();
    exp_mem[0] = {seed, 3'd0};
    repeat (20) @(negedge clk);
    rd(4'd0, d);
    chk("R10 run low after abort", 32'(d[0]), 32'd0);
    chk("R10 done not set by abort", 32'(d[6]), 32'd0);
    check_results("R10 aborted result not stored");

    // R11/R12 abort then immediate restart in group 1
    expect_pass(1'b0, 2'd3, 1'b1);
    wr_ctrl(1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1);
    do @(negedge clk); while (!(conv_start && conv_chan == 3'd1));
    wr_ctrl(1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1);
    sb_q.delete();
    exp_mem[0] = {seed, 3'd0};
    expect_pass(1'b1, 2'd1, 1'b1);
    wr_ctrl(1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1);
    wait_idle();
    commit(1'b1, 2'd1, 1'b1);
    rd(4'd0, d);
    chk("R11 restart pass completes", 32'(d[6]), 32'd1);
    check_results("R11/R12 restart results");

    repeat (10) @(negedge clk);
    chk("R13 scoreboard drained", 32'(sb_q.size()), 32'd0);
    finish_run();
  end

endmodule